// File: doc/BRIEF.md
# DAC Register-Access Transfer Controller

This block sits on the host side of a multi-lane serial link to an external DAC. It lets a processor carry register accesses to the converter. Software programs a target address, write data, a symbol size and a link timing mode through a small word-addressed register file. Writing the start bit launches a frame. The controller then lowers chip-select and shifts out the address byte followed by the data symbol, most significant bit first, on one, two or four data lanes. It reports busy until the last beat has left.

A read uses the same frame with bit 7 of the address set. During the data phase the controller releases its lanes, samples the returned bits and places them in a readback register as busy falls. In stream mode, started by setting the stream and start bits in the same write, the controller sends the address once. It then sends one data symbol after another taken from a sample port, and stops at the next symbol boundary once software clears either bit.

Register word offsets: 0 control, 1 write data, 2 mode, 3 readback, 4 status. Reads are combinational from the read address.

Top module: `dac_xfer_ctrl`

## Requirements
- R1: After reset the control, write-data and readback words read 0, the mode word reads 2 (two-edge timing off, 16-bit symbols), status reads 0, chip-select is high, and the clock and data lanes are low.
- R2: The control word holds the target address in bits 31:24, the lane mode in bits 3:2 (0 one lane, 1 two lanes, 2 four lanes), stream in bit 1 and start in bit 0. A lane-mode value of 3 is ignored and the previous lane mode is kept.
- R3: A control write that sets bit 0 while the stored start bit is 0 and the link is idle lowers chip-select and raises status bit 4 in the next cycle.
- R4: A frame carries the 8-bit address and then the data symbol, both MSB first. With mode bit 0 set the symbol is 8 bits from write-data bits 23:16; with it clear the symbol is 16 bits from write-data bits 23:8.
- R5: Lane mode 0, 1 and 2 moves 1, 2 or 4 bits per beat on data lanes [0], [1:0] and [3:0], with the higher lane carrying the earlier bit. Unused lanes stay 0.
- R6: With mode bit 1 set each beat lasts two cycles, with the clock low in the first and high in the second. With it clear each cycle is one beat and the clock toggles on every beat, starting low. Busy lasts beats times 2 or beats cycles.
- R7: When address bit 7 is set, the lane output enable is low during the data phase. The returned lane bits are sampled at the end of each beat, with the same lane mapping, and the zero-extended symbol appears in the readback word in the cycle busy falls.
- R8: A frame whose address bit 7 is clear leaves the readback word unchanged.
- R9: While busy, writes to the write-data word, the mode word, and the address and lane fields of the control word are ignored.
- R10: With stream and start set in the launching write, the address is followed by consecutive symbols from the sample input. Each latch of the sample input is flagged by a one-cycle take pulse in the next cycle. After stream or start is cleared, the current symbol completes and the frame ends.
- R11: Chip-select rises in the same cycle busy falls. While chip-select is high, the clock, data lanes and output enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Register write word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 3 | Register read word offset |
| reg_rdata_o | output | 32 | Register read data, combinational |
| sample_i | input | 16 | Stream sample data |
| sample_take_o | output | 1 | Pulse: sample input was latched on the previous edge |
| sclk_o | output | 1 | Serial clock to the DAC |
| cs_n_o | output | 1 | Active-low chip-select |
| sdo_o | output | 4 | Serial data lanes toward the DAC |
| sdo_oe_o | output | 1 | Lane output enable |
| sdi_i | input | 4 | Serial data lanes from the DAC |

## Verification
The launching write lands on edge E. Chip-select, busy and the first beat are visible in the cycle after E. Each later beat follows two cycles apart in single-edge timing and one cycle apart in two-edge timing, so busy is due to fall exactly 2N or N cycles after E, and the readback value is due in that same cycle. The bench samples at the falling edge: a beat is taken in the clock-high half in single-edge timing and in every cycle otherwise. The responder's lanes are changed at the same falling edge, so they are stable at the rising edge where the controller samples them. The sample take pulse is expected one cycle after each symbol boundary, and a stop written mid-symbol is expected to end the frame only at the next boundary.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int HALF_W  = DATA_W / 2;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int LANE_W  = 4;
  localparam int REG_AW  = 3;
  localparam int WF_LSB  = 8;
  localparam int BUSY_BIT = 4;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_WDATA = 3'd1;
  localparam logic [REG_AW-1:0] RA_MODE  = 3'd2;
  localparam logic [REG_AW-1:0] RA_RDBK  = 3'd3;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd4;

  typedef enum logic [1:0] {
    LN_X1 = 2'd0,
    LN_X2 = 2'd1,
    LN_X4 = 2'd2
  } lane_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    lane_e             lanes;
    logic              stream;
    logic              xfer;
  } ctrl_t;

  typedef struct packed {
    logic sdr;
    logic sym8;
  } mode_t;
endpackage

// File: rtl/dac_xfer_regs.sv
module dac_xfer_regs
  import dac_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [31:0]       wdata_i,
  input  logic [REG_AW-1:0] raddr_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              rd_done_i,
  input  logic [DATA_W-1:0] rd_val_i,
  output logic              start_o,
  output ctrl_t             launch_o,
  output ctrl_t             ctrl_o,
  output mode_t             mode_o,
  output logic [DATA_W-1:0] wfield_o
);
  ctrl_t             ctrl_q, wr_ctrl;
  mode_t             mode_q;
  logic [31:0]       wdata_q;
  logic [DATA_W-1:0] rdbk_q;
  logic              ctrl_we;

  assign ctrl_we = we_i && (waddr_i == RA_CTRL);

  always_comb begin
    wr_ctrl.addr   = wdata_i[31:24];
    wr_ctrl.lanes  = (wdata_i[3:2] == 2'd3) ? ctrl_q.lanes : lane_e'(wdata_i[3:2]);
    wr_ctrl.stream = wdata_i[1];
    wr_ctrl.xfer   = wdata_i[0];
  end

  assign start_o  = ctrl_we && wdata_i[0] && !ctrl_q.xfer && !busy_i;
  assign launch_o = wr_ctrl;
  assign ctrl_o   = ctrl_q;
  assign mode_o   = mode_q;
  assign wfield_o = wdata_q[WF_LSB +: DATA_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      mode_q  <= '{sdr: 1'b1, sym8: 1'b0};
      wdata_q <= '0;
      rdbk_q  <= '0;
    end else begin
      if (ctrl_we) begin
        if (busy_i) begin
          ctrl_q.stream <= wr_ctrl.stream;
          ctrl_q.xfer   <= wr_ctrl.xfer;
        end else begin
          ctrl_q <= wr_ctrl;
        end
      end
      if (we_i && !busy_i && waddr_i == RA_WDATA) wdata_q <= wdata_i;
      if (we_i && !busy_i && waddr_i == RA_MODE)  mode_q  <= mode_t'(wdata_i[1:0]);
      if (rd_done_i) rdbk_q <= rd_val_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (raddr_i)
      RA_CTRL:  rdata_o = {ctrl_q.addr, 20'h0, ctrl_q.lanes, ctrl_q.stream, ctrl_q.xfer};
      RA_WDATA: rdata_o = wdata_q;
      RA_MODE:  rdata_o = {30'h0, mode_q.sdr, mode_q.sym8};
      RA_RDBK:  rdata_o = {{(32-DATA_W){1'b0}}, rdbk_q};
      RA_STAT:  rdata_o = 32'(busy_i) << BUSY_BIT;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dac_xfer_shift.sv
module dac_xfer_shift
  import dac_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] launch_addr_i,
  input  lane_e             launch_lanes_i,
  input  logic              launch_strm_i,
  input  logic              run_i,
  input  mode_t             mode_i,
  input  logic [DATA_W-1:0] wfield_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic [LANE_W-1:0] sdi_i,
  output logic              busy_o,
  output logic              rd_done_o,
  output logic [DATA_W-1:0] rd_val_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic [LANE_W-1:0] sdo_o,
  output logic              sdo_oe_o,
  output logic              take_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic               busy_q, ph_q, sclk_q, is_rd_q, strm_q, sym8_q, sdr_q, take_q;
  lane_e              lanes_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q, lw, tot;
  logic [DATA_W-1:0]  rsh_q, rnext;
  logic [LANE_W-1:0]  out_sl, in_sl;
  logic               adv, last, data_ph, keep;

  // data symbol left-aligned in a DATA_W field
  function automatic logic [DATA_W-1:0] place(logic s8, logic [DATA_W-1:0] d16,
                                              logic [HALF_W-1:0] d8);
    return s8 ? {d8, {HALF_W{1'b0}}} : d16;
  endfunction

  always_comb begin
    case (lanes_q)
      LN_X2: begin
        lw = CNT_W'(2);
        out_sl = {2'b00, sh_q[FRAME_W-1 -: 2]};
        in_sl  = {2'b00, sdi_i[1:0]};
      end
      LN_X4: begin
        lw = CNT_W'(4);
        out_sl = sh_q[FRAME_W-1 -: 4];
        in_sl  = sdi_i;
      end
      default: begin
        lw = CNT_W'(1);
        out_sl = {3'b000, sh_q[FRAME_W-1]};
        in_sl  = {3'b000, sdi_i[0]};
      end
    endcase
  end

  assign tot     = sym8_q ? CNT_W'(ADDR_W + HALF_W) : CNT_W'(FRAME_W);
  assign adv     = busy_q && (!sdr_q || ph_q);
  assign last    = (cnt_q + lw) == tot;
  assign data_ph = cnt_q >= CNT_W'(ADDR_W);
  assign keep    = strm_q && run_i;
  assign rnext   = (rsh_q << lw) | DATA_W'(in_sl);

  assign rd_done_o = adv && last && !keep && is_rd_q;
  assign rd_val_o  = sym8_q ? {{HALF_W{1'b0}}, rnext[HALF_W-1:0]} : rnext;
  assign busy_o    = busy_q;
  assign cs_n_o    = !busy_q;
  assign sclk_o    = busy_q && (sdr_q ? ph_q : sclk_q);
  assign sdo_oe_o  = busy_q && !(is_rd_q && data_ph);
  assign sdo_o     = sdo_oe_o ? out_sl : '0;
  assign take_o    = take_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      ph_q    <= 1'b0;
      sclk_q  <= 1'b0;
      is_rd_q <= 1'b0;
      strm_q  <= 1'b0;
      sym8_q  <= 1'b0;
      sdr_q   <= 1'b0;
      take_q  <= 1'b0;
      lanes_q <= LN_X1;
      sh_q    <= '0;
      cnt_q   <= '0;
      rsh_q   <= '0;
    end else begin
      take_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        ph_q    <= 1'b0;
        sclk_q  <= 1'b0;
        cnt_q   <= '0;
        rsh_q   <= '0;
        is_rd_q <= launch_addr_i[ADDR_W-1];
        strm_q  <= launch_strm_i;
        take_q  <= launch_strm_i;
        sym8_q  <= mode_i.sym8;
        sdr_q   <= mode_i.sdr;
        lanes_q <= launch_lanes_i;
        sh_q    <= {launch_addr_i,
                    place(mode_i.sym8,
                          launch_strm_i ? sample_i : wfield_i,
                          launch_strm_i ? sample_i[HALF_W-1:0] : wfield_i[DATA_W-1 -: HALF_W])};
      end else if (busy_q) begin
        ph_q <= sdr_q && !ph_q;
        if (adv) begin
          if (is_rd_q && data_ph) rsh_q <= rnext;
          if (!sdr_q) sclk_q <= !sclk_q;
          if (last) begin
            if (keep) begin
              sh_q   <= {place(sym8_q, sample_i, sample_i[HALF_W-1:0]), {ADDR_W{1'b0}}};
              cnt_q  <= CNT_W'(ADDR_W);
              take_q <= 1'b1;
            end else begin
              busy_q <= 1'b0;
            end
          end else begin
            sh_q  <= sh_q << lw;
            cnt_q <= cnt_q + lw;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dac_xfer_ctrl.sv
module dac_xfer_ctrl
  import dac_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_waddr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [REG_AW-1:0] reg_raddr_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sample_take_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic [LANE_W-1:0] sdo_o,
  output logic              sdo_oe_o,
  input  logic [LANE_W-1:0] sdi_i
);
  ctrl_t             ctrl, launch;
  mode_t             mode;
  logic [DATA_W-1:0] wfield, rd_val;
  logic              busy, start, rd_done;

  dac_xfer_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .waddr_i   (reg_waddr_i),
    .wdata_i   (reg_wdata_i),
    .raddr_i   (reg_raddr_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy),
    .rd_done_i (rd_done),
    .rd_val_i  (rd_val),
    .start_o   (start),
    .launch_o  (launch),
    .ctrl_o    (ctrl),
    .mode_o    (mode),
    .wfield_o  (wfield)
  );

  dac_xfer_shift u_shift (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .launch_addr_i  (launch.addr),
    .launch_lanes_i (launch.lanes),
    .launch_strm_i  (launch.stream),
    .run_i          (ctrl.stream && ctrl.xfer),
    .mode_i         (mode),
    .wfield_i       (wfield),
    .sample_i       (sample_i),
    .sdi_i          (sdi_i),
    .busy_o         (busy),
    .rd_done_o      (rd_done),
    .rd_val_o       (rd_val),
    .sclk_o         (sclk_o),
    .cs_n_o         (cs_n_o),
    .sdo_o          (sdo_o),
    .sdo_oe_o       (sdo_oe_o),
    .take_o         (sample_take_o)
  );
endmodule

// File: rtl/dac_xfer_ctrl_chk.sv
module dac_xfer_ctrl_chk
  import dac_xfer_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic              start_bit_i,
  input logic              xfer_i,
  input logic [1:0]        lanes_i,
  input logic [1:0]        mode_i,
  input logic              busy_i,
  input logic              cs_n_i,
  input logic              sclk_i,
  input logic [LANE_W-1:0] sdo_i,
  input logic              sdo_oe_i
);
  AST_START_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && start_bit_i && !xfer_i && !busy_i) |=> (busy_i && !cs_n_i)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> (sdo_i == '0 && !sclk_i && !sdo_oe_i)); // R11

  AST_ONE_LANE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && lanes_i == 2'd0) |-> (sdo_i[3:1] == 3'b000)); // R5

  AST_TWO_LANES_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && lanes_i == 2'd1) |-> (sdo_i[3:2] == 2'b00)); // R5

  AST_LANE_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lanes_i != 2'd3); // R2

  AST_CFG_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> ($stable(mode_i) && $stable(lanes_i))); // R9

  AST_SDR_CLOCK_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i) && mode_i[1]) |-> (sclk_i != $past(sclk_i))); // R6
endmodule

bind dac_xfer_ctrl dac_xfer_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (reg_we_i && (reg_waddr_i == 3'd0)),
  .start_bit_i (reg_wdata_i[0]),
  .xfer_i      (ctrl.xfer),
  .lanes_i     (ctrl.lanes),
  .mode_i      (mode),
  .busy_i      (busy),
  .cs_n_i      (cs_n_o),
  .sclk_i      (sclk_o),
  .sdo_i       (sdo_o),
  .sdo_oe_i    (sdo_oe_o)
);

// File: tb/dac_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module dac_xfer_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  raddr = '0;
  logic [31:0] rdata;
  logic [15:0] sample = '0;
  logic        take;
  logic        sclk, cs_n, oe;
  logic [3:0]  sdo;
  logic [3:0]  sdi = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  dac_xfer_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_waddr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .sample_i(sample), .sample_take_o(take), .sclk_o(sclk), .cs_n_o(cs_n),
    .sdo_o(sdo), .sdo_oe_o(oe), .sdi_i(sdi)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    raddr = a;
    #0.1;
    d = rdata;
  endtask

  task automatic run_frame(input logic [7:0] addr, input logic [15:0] dv, input bit sym8,
                           input bit sdr, input int lanes, input logic [15:0] resp, input bit poke);
    int dw, w, n, cyc, k, bad_lane, bad_oe, bad_clk;
    logic [31:0] old_rb, v, ctrlw, wd, mask, dmask;
    logic [63:0] got, exp;
    bit is_rd;
    dw = sym8 ? 8 : 16;
    w = 1 << lanes;
    n = (8 + dw) / w;
    mask = (32'd1 << w) - 1;
    dmask = (32'd1 << dw) - 1;
    is_rd = addr[7];
    wd = sym8 ? {8'h0, dv[7:0], 16'h0} : {8'h0, dv, 8'h0};
    ctrlw = {addr, 20'h0, 2'(lanes), 1'b0, 1'b1};
    wr(3'd2, {30'h0, sdr, sym8});
    wr(3'd1, wd);
    rd(3'd3, old_rb);
    wr(3'd0, ctrlw);
    rd(3'd4, v);
    chk("R3 busy next cycle", {v[4], cs_n}, 2'b10);
    cyc = 0; k = 0; got = '0; bad_lane = 0; bad_oe = 0; bad_clk = 0;
    while (!cs_n && cyc < 1000) begin
      cyc++;
      if (!sdr || sclk) begin
        if (!sdr && sclk !== k[0]) bad_clk++;
        if ((32'(sdo) >> w) != 0) bad_lane++;
        if (oe !== !(is_rd && k * w >= 8)) bad_oe++;
        got = (got << w) | 64'(32'(sdo) & mask);
        if (is_rd && k * w >= 8)
          sdi = 4'((32'(resp) >> (dw - (k - 8 / w + 1) * w)) & mask);
        else
          sdi = '0;
        k++;
      end
      if (poke) begin
        case (cyc)
          2: begin we = 1'b1; waddr = 3'd1; wdata = 32'hFFFF_FFFF; end
          3: begin waddr = 3'd2; wdata = 32'h0; end
          4: begin waddr = 3'd0; wdata = 32'h5500_0005; end
          5: we = 1'b0;
          default: ;
        endcase
      end
      @(negedge clk);
    end
    sdi = '0;
    exp = is_rd ? (64'(addr) << dw) : ((64'(addr) << dw) | 64'(32'(dv) & dmask));
    chk("R4 frame bits", got, exp);
    chk("R5 beat count", 64'(k), 64'(n));
    chk("R5 unused lanes zero", 64'(bad_lane), 0);
    chk("R6 busy cycles", 64'(cyc), 64'(sdr ? 2 * n : n));
    if (!sdr) chk("R6 two-edge clock phase", 64'(bad_clk), 0);
    chk("R7 output enable", 64'(bad_oe), 0);
    rd(3'd4, v);
    chk("R11 busy low with cs high", {v[4], cs_n}, 2'b01);
    rd(3'd3, v);
    if (is_rd) chk("R7 readback", v, 32'(resp) & dmask);
    else       chk("R8 readback kept", v, old_rb);
    if (poke) begin
      rd(3'd1, v); chk("R9 wdata held", v, wd);
      rd(3'd2, v); chk("R9 mode held", v, {30'h0, sdr, sym8});
      rd(3'd0, v); chk("R9 ctrl addr/lanes held", v, ctrlw);
    end
    wr(3'd0, {ctrlw[31:1], 1'b0});
  endtask

  task automatic run_stream();
    logic [63:0] got;
    logic [31:0] v;
    int k, takes;
    sample = 16'hA000;
    wr(3'd2, 32'h0);
    wr(3'd0, {8'h20, 20'h0, 2'd2, 1'b1, 1'b1});
    k = 0; takes = 0; got = '0;
    while (!cs_n && k < 200) begin
      if (take) begin takes++; sample = sample + 16'd1; end
      got = (got << 4) | 64'(sdo);
      k++;
      if (k == 12) begin we = 1'b1; waddr = 3'd0; wdata = {8'h20, 20'h0, 2'd2, 2'b00}; end
      else we = 1'b0;
      @(negedge clk);
    end
    we = 1'b0;
    chk("R10 stream beats", 64'(k), 64'd14);
    chk("R10 stream data", got, {8'h00, 8'h20, 16'hA000, 16'hA001, 16'hA002});
    chk("R10 take pulses", 64'(takes), 64'd3);
    rd(3'd4, v);
    chk("R10 idle after stop", {v[4], cs_n}, 2'b01);
  endtask

  initial begin
    logic [31:0] v;
    #1;
    chk("R1 cs high in reset", 64'(cs_n), 1);
    chk("R1 lanes quiet in reset", {sdo, sclk, oe}, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 ctrl reset", v, 0);
    rd(3'd1, v); chk("R1 wdata reset", v, 0);
    rd(3'd2, v); chk("R1 mode reset", v, 2);
    rd(3'd3, v); chk("R1 readback reset", v, 0);
    rd(3'd4, v); chk("R1 status reset", v, 0);

    wr(3'd0, 32'hAB00_0004);
    rd(3'd0, v); chk("R2 ctrl fields", v, 32'hAB00_0004);
    wr(3'd0, 32'hCD00_000C);
    rd(3'd0, v); chk("R2 lane mode 3 ignored", v, 32'hCD00_0004);
    wr(3'd0, 32'h0);

    for (int ln = 0; ln < 3; ln++)
      for (int s = 0; s < 2; s++)
        for (int b = 0; b < 2; b++)
          for (int r = 0; r < 2; r++)
            run_frame(r ? 8'(8'h80 | (ln * 16 + s * 4 + b)) : 8'(8'h13 + ln * 8 + s * 2 + b),
                      16'hC35A ^ 16'(ln * 16'h1111 + s * 16'h0F0F + b * 16'h0303),
                      bit'(b), bit'(s), ln,
                      16'h9D6B ^ 16'(ln * 16'h2222 + s * 16'h0101 + b * 16'h4040), 1'b0);

    run_frame(8'h2E, 16'h8421, 1'b0, 1'b1, 0, 16'h0, 1'b1);
    run_stream();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule